// File: doc/BRIEF.md
# Header-Gated Byte Receiver for Half-Duplex SPI

This block drives the receive side of an SPI master that talks to a peripheral which answers only after a variable run of idle or junk bytes. After a start pulse the block asks the master for one all-ones filler byte at a time. Each filler byte clocks one byte back from the peripheral. Incoming bytes are thrown away until one equals the configured header value. The header itself is dropped as well. The block then passes exactly the requested number of following bytes to its output stream and ends the transaction with a one-cycle done pulse.

Only one filler byte is ever outstanding. A new one is asked for only after the byte clocked by the previous one has come back, so the receive path never holds more than one unread byte, even when the peripheral streams a long answer. The caller can set a limit on how many junk bytes are tolerated while hunting. When the limit is reached, the transaction ends with an error indication instead of hunting without end. The byte count, header value and limit are all captured when the start pulse is accepted.

Top module: `hdr_hunt_rx`

## Requirements
- R1: After reset the block is idle: `busy`, `txReq`, `outValid`, `done` and `hdrMiss` are all 0.
- R2: A start pulse while idle captures `byteCount`, `headerByte` and `discardLimit` and begins hunting, with `busy` high from the next cycle. A start pulse while busy is ignored and changes neither the running transaction nor its captured settings.
- R3: While hunting or capturing, `txReq` is a single-cycle request for one filler byte with `txByte` = 0xFF. No further request is made until a received byte (`rxValid`) has arrived. The total number of requests in a transaction equals the number of bytes the block consumes.
- R4: Every received byte before the header is discarded without output. The header byte itself is not output. A match needs all 8 bits equal to the captured header value, so bytes differing in any bit (for example 0xED, 0x6C or 0xEE against 0xEC) are discarded.
- R5: After the header, exactly the captured count of bytes is delivered on `outData` with `outValid`, in arrival order, one cycle after each arrives. `done` is high in the same cycle as the last delivered byte.
- R6: With a count of 0, `done` follows the header byte by one cycle. No byte is delivered and no filler is requested after the header.
- R7: With a nonzero limit L, the L-th discarded non-header byte ends the transaction: `done` and `hdrMiss` are high together and no byte is delivered. If that byte is the header instead, the transaction goes on normally.
- R8: A limit of 0 disables the abort, so any number of junk bytes may precede the header.
- R9: During capture, a byte equal to the header value is delivered as ordinary data and does not restart the hunt.
- R10: `done` lasts one cycle and the block is idle (`busy` low) in the following cycle. `hdrMiss` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a transaction (taken only when idle) |
| byteCount | input | CNT_W | Number of bytes to deliver after the header |
| headerByte | input | 8 | Header value to hunt for |
| discardLimit | input | LIM_W | Junk bytes tolerated before abort; 0 = unlimited |
| rxValid | input | 1 | A byte has been received by the master |
| rxData | input | 8 | The received byte |
| txReq | output | 1 | Request to send one filler byte |
| txByte | output | 8 | Filler value to send (all ones) |
| outValid | output | 1 | A captured byte is on `outData` |
| outData | output | 8 | Captured byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| hdrMiss | output | 1 | With `done`: ended by the discard limit |

## Verification
Two functions can fall in the same cycle. The first is delivery of the last captured byte together with the done pulse. The bench runs payloads of several lengths and checks at each done pulse that `outValid` is high in that same cycle and that the expected-byte queue has just been emptied. The second is the hunt limit falling on the header byte itself. This is provoked by placing the header exactly at the limit position, and judged by a normal delivery with `hdrMiss` low, while a junk byte at the same position must give an abort with no output.

// File: rtl/hdr_hunt_pkg.sv
package hdr_hunt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_HUNT    = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_DONE    = 2'd3
  } huntState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture configuration, clear counters
    logic issue;    // one filler byte requested this cycle
    logic discard;  // a non-header byte dropped while hunting
    logic capture;  // a payload byte taken
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic hdrMatch;   // current received byte equals header
    logic countZero;  // nothing left to deliver
    logic lastByte;   // exactly one byte left
    logic limitHit;   // this discard reaches the limit
    logic pending;    // a filler byte is outstanding
  } dpStatus_t;

endpackage

// File: rtl/hdr_hunt_ctrl.sv
module hdr_hunt_ctrl
  import hdr_hunt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      rxValid,
  input  dpStatus_t stat,
  output dpStrobe_t strb,
  output logic      busy,
  output logic      done,
  output logic      hdrMiss
);

  huntState_e state, stateNxt;
  logic       errReg;
  logic       errSet;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    errSet   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strb.load = 1'b1;
          stateNxt  = ST_HUNT;
        end
      end
      ST_HUNT: begin
        strb.issue = !stat.pending;
        if (rxValid) begin
          if (stat.hdrMatch) begin
            // header has priority over the limit on the same byte
            stateNxt = stat.countZero ? ST_DONE : ST_CAPTURE;
          end else begin
            strb.discard = 1'b1;
            if (stat.limitHit) begin
              stateNxt = ST_DONE;
              errSet   = 1'b1;
            end
          end
        end
      end
      ST_CAPTURE: begin
        strb.issue = !stat.pending;
        if (rxValid) begin
          strb.capture = 1'b1;
          if (stat.lastByte) stateNxt = ST_DONE;
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      errReg <= 1'b0;
    end else begin
      state <= stateNxt;
      if (strb.load)   errReg <= 1'b0;
      else if (errSet) errReg <= 1'b1;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign hdrMiss = (state == ST_DONE) && errReg;

endmodule

// File: rtl/hdr_hunt_dp.sv
module hdr_hunt_dp
  import hdr_hunt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [7:0]       headerByte,
  input  logic [LIM_W-1:0] discardLimit,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  output dpStatus_t        stat,
  output logic             outValid,
  output logic [7:0]       outData
);

  logic [7:0]       hdrReg;
  logic [CNT_W-1:0] remainCnt;
  logic [LIM_W-1:0] limReg;
  logic [LIM_W-1:0] dropCnt;
  logic             pendReg;

  // configuration and counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrReg    <= '0;
      remainCnt <= '0;
      limReg    <= '0;
      dropCnt   <= '0;
    end else if (strb.load) begin
      hdrReg    <= headerByte;
      remainCnt <= byteCount;
      limReg    <= discardLimit;
      dropCnt   <= '0;
    end else begin
      if (strb.capture) remainCnt <= remainCnt - CNT_W'(1);
      if (strb.discard) dropCnt   <= dropCnt + LIM_W'(1);
    end
  end

  // single outstanding filler byte
  always_ff @(posedge clk) begin
    if (!rstN)           pendReg <= 1'b0;
    else if (strb.load)  pendReg <= 1'b0;
    else if (strb.issue) pendReg <= 1'b1;
    else if (rxValid)    pendReg <= 1'b0;
  end

  // registered output stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strb.capture;
      if (strb.capture) outData <= rxData;
    end
  end

  always_comb begin
    stat.hdrMatch  = (rxData == hdrReg);
    stat.countZero = (remainCnt == '0);
    stat.lastByte  = (remainCnt == CNT_W'(1));
    stat.limitHit  = (limReg != '0) && (dropCnt == (limReg - LIM_W'(1)));
    stat.pending   = pendReg;
  end

endmodule

// File: rtl/hdr_hunt_rx.sv
module hdr_hunt_rx
  import hdr_hunt_pkg::*;
#(
  parameter int         CNT_W     = 16,
  parameter int         LIM_W     = 8,
  parameter logic [7:0] FILL_BYTE = 8'hFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [7:0]       headerByte,
  input  logic [LIM_W-1:0] discardLimit,
  input  logic             rxValid,
  input  logic [7:0]       rxData,
  output logic             txReq,
  output logic [7:0]       txByte,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic             busy,
  output logic             done,
  output logic             hdrMiss
);

  dpStrobe_t strb;
  dpStatus_t stat;

  hdr_hunt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .rxValid    (rxValid),
    .stat       (stat),
    .strb       (strb),
    .busy       (busy),
    .done       (done),
    .hdrMiss    (hdrMiss)
  );

  hdr_hunt_dp #(
    .CNT_W (CNT_W),
    .LIM_W (LIM_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .byteCount    (byteCount),
    .headerByte   (headerByte),
    .discardLimit (discardLimit),
    .rxValid      (rxValid),
    .rxData       (rxData),
    .stat         (stat),
    .outValid     (outValid),
    .outData      (outData)
  );

  assign txReq  = strb.issue;
  assign txByte = FILL_BYTE;

endmodule

// File: rtl/hdr_hunt_chk.sv
module hdr_hunt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [CNT_W-1:0] byteCount,
  input logic             rxValid,
  input logic             txReq,
  input logic             outValid,
  input logic             busy,
  input logic             done,
  input logic             hdrMiss
);

  logic [CNT_W:0] seenCnt;
  logic [CNT_W:0] wantCnt;
  logic [CNT_W:0] finalCnt;

  assign finalCnt = seenCnt + {{CNT_W{1'b0}}, outValid};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenCnt <= '0;
      wantCnt <= '0;
    end else begin
      if (!busy && startPulse) begin
        wantCnt <= {1'b0, byteCount};
        seenCnt <= '0;
      end else if (outValid) begin
        seenCnt <= seenCnt + 1'b1;
      end
      if (done && !hdrMiss) begin
        p_exact_count_r5: assert (finalCnt == wantCnt)
          else $error("delivered byte count differs from request");
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!txReq && !outValid && !done && !hdrMiss));

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && startPulse) |=> busy);

  p_one_filler_r3: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> !txReq);

  p_rx_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && !txReq && !rxValid && !$past(txReq) && $past(busy)) |=> !txReq || rxValid || $past(rxValid));

  p_miss_no_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    hdrMiss |-> (done && !outValid));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

endmodule

bind hdr_hunt_rx hdr_hunt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .byteCount  (byteCount),
  .rxValid    (rxValid),
  .txReq      (txReq),
  .outValid   (outValid),
  .busy       (busy),
  .done       (done),
  .hdrMiss    (hdrMiss)
);

// File: tb/hdr_hunt_rx_tb.sv
module hdr_hunt_rx_tb;

  localparam int CNT_W = 16;
  localparam int LIM_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startPulse = 1'b0;
  logic [CNT_W-1:0] byteCount = '0;
  logic [7:0]       headerByte = 8'hEC;
  logic [LIM_W-1:0] discardLimit = '0;
  logic             rxValid = 1'b0;
  logic [7:0]       rxData = '0;
  logic             txReq, outValid, busy, done, hdrMiss;
  logic [7:0]       txByte, outData;

  hdr_hunt_rx #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .byteCount(byteCount),
    .headerByte(headerByte), .discardLimit(discardLimit), .rxValid(rxValid),
    .rxData(rxData), .txReq(txReq), .txByte(txByte), .outValid(outValid),
    .outData(outData), .busy(busy), .done(done), .hdrMiss(hdrMiss)
  );

  always #4 clk = ~clk;  // 125 MHz

  int nChecks = 0;
  int nErrors = 0;
  int cycles  = 0;

  logic [7:0] periph[$];   // what the peripheral will answer
  logic [7:0] expQ[$];     // scoreboard of expected output bytes
  logic [7:0] preQ[$];
  logic [7:0] payQ[$];
  bit   expErr = 1'b0;
  bit   expLastWithDone = 1'b0;
  bit   doneSeen = 1'b0;
  int   txSeen = 0;
  int   lat = 1;
  int   countDown = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // SPI master model: each filler request returns one byte after lat cycles
  initial begin
    forever begin
      @(negedge clk);
      rxValid = 1'b0;
      if (countDown > 0) begin
        countDown--;
        if (countDown == 0) begin
          rxValid = 1'b1;
          rxData  = (periph.size() > 0) ? periph.pop_front() : 8'h00;
        end
      end
      if (txReq) countDown = lat;
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (txReq) begin
          txSeen++;
          check(txByte == 8'hFF, "R3", "filler value", txByte, 8'hFF);
        end
        if (outValid) begin
          if (expQ.size() == 0)
            check(1'b0, "R4", "unexpected output byte", outData, 0);
          else begin
            logic [7:0] e;
            e = expQ.pop_front();
            check(outData == e, "R5", "output byte", outData, e);
          end
        end
        if (done) begin
          doneSeen = 1'b1;
          check(hdrMiss == expErr, "R7", "abort flag at done", hdrMiss, expErr);
          check(expQ.size() == 0, "R5", "bytes left undelivered", expQ.size(), 0);
          if (expLastWithDone)
            check(outValid == 1'b1, "R5", "last byte with done", outValid, 1);
        end
      end
    end
  end

  task automatic runTxn(input string tag, input logic [7:0] hdr, input int cnt,
                        input int lim, input int latency, input bit errCase,
                        input bit pokeStart);
    int expTx;
    periph.delete();
    expQ.delete();
    foreach (preQ[i]) periph.push_back(preQ[i]);
    periph.push_back(hdr);
    foreach (payQ[i]) periph.push_back(payQ[i]);
    for (int i = 0; i < 4; i++) periph.push_back(8'h33);
    if (!errCase) foreach (payQ[i]) expQ.push_back(payQ[i]);
    expTx = errCase ? lim : (preQ.size() + 1 + cnt);
    @(negedge clk);
    headerByte      = hdr;
    byteCount       = CNT_W'(cnt);
    discardLimit    = LIM_W'(lim);
    lat             = latency;
    expErr          = errCase;
    expLastWithDone = !errCase && (cnt > 0);
    txSeen          = 0;
    doneSeen        = 1'b0;
    startPulse      = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(busy == 1'b1, "R2", {tag, " busy after start"}, busy, 1);
    if (pokeStart) begin
      repeat (3) @(negedge clk);
      byteCount    = CNT_W'(cnt + 5);
      headerByte   = 8'h00;
      discardLimit = LIM_W'(1);
      startPulse   = 1'b1;
      @(negedge clk);
      startPulse = 1'b0;
    end
    for (int i = 0; i < 3000 && !doneSeen; i++) @(negedge clk);
    @(negedge clk);
    check(doneSeen, "R10", {tag, " done reached"}, doneSeen, 1);
    check(busy == 1'b0, "R10", {tag, " idle after done"}, busy, 0);
    check(txSeen == expTx, "R3", {tag, " filler request count"}, txSeen, expTx);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(busy == 0,     "R1", "busy in reset",     busy, 0);
    check(txReq == 0,    "R1", "txReq in reset",    txReq, 0);
    check(outValid == 0, "R1", "outValid in reset", outValid, 0);
    check(done == 0,     "R1", "done in reset",     done, 0);
    check(hdrMiss == 0,  "R1", "hdrMiss in reset",  hdrMiss, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && txReq == 0, "R1", "idle after reset", busy, 0);

    // R4 R5: near-miss junk then four bytes
    preQ.delete(); payQ.delete();
    preQ.push_back(8'h00); preQ.push_back(8'hED); preQ.push_back(8'h6C);
    preQ.push_back(8'hEE); preQ.push_back(8'hFF);
    payQ.push_back(8'h11); payQ.push_back(8'h22); payQ.push_back(8'h33); payQ.push_back(8'h44);
    runTxn("near-miss", 8'hEC, 4, 0, 1, 1'b0, 1'b0);

    // R9: header value inside payload, header first on the line
    preQ.delete(); payQ.delete();
    payQ.push_back(8'hEC); payQ.push_back(8'h01); payQ.push_back(8'hEC);
    runTxn("hdr-in-data", 8'hEC, 3, 4, 2, 1'b0, 1'b0);

    // R6: zero count
    preQ.delete(); payQ.delete();
    preQ.push_back(8'hAA); preQ.push_back(8'hBB);
    runTxn("zero-count", 8'hEC, 0, 0, 1, 1'b0, 1'b0);

    // R7: abort on third junk byte
    preQ.delete(); payQ.delete();
    for (int i = 0; i < 5; i++) preQ.push_back(8'(8'h40 + i));
    runTxn("abort", 8'hEC, 4, 3, 1, 1'b1, 1'b0);

    // R7: abort on the very first byte with limit 1
    runTxn("abort-first", 8'hEC, 2, 1, 3, 1'b1, 1'b0);

    // R7: header lands on the limit position and wins
    preQ.delete(); payQ.delete();
    preQ.push_back(8'h01); preQ.push_back(8'h02);
    payQ.push_back(8'h55);
    runTxn("hdr-at-limit", 8'hEC, 1, 3, 1, 1'b0, 1'b0);

    // R8: unlimited hunt over 20 junk bytes
    preQ.delete(); payQ.delete();
    for (int i = 0; i < 20; i++) preQ.push_back(8'(i * 3 + 1));
    payQ.push_back(8'h9A); payQ.push_back(8'h9B);
    runTxn("unlimited", 8'hEC, 2, 0, 2, 1'b0, 1'b0);

    // R2: start pulse while busy is ignored; other header value
    preQ.delete(); payQ.delete();
    preQ.push_back(8'h5B); preQ.push_back(8'h00); preQ.push_back(8'h77);
    for (int i = 0; i < 6; i++) payQ.push_back(8'(8'hA1 + i));
    runTxn("busy-start", 8'h5A, 6, 0, 3, 1'b0, 1'b1);

    // R5: long payload, fast turnaround
    preQ.delete(); payQ.delete();
    preQ.push_back(8'h12);
    for (int i = 0; i < 40; i++) payQ.push_back(8'((i * 37) ^ 8'h5A));
    runTxn("long", 8'hEC, 40, 8, 1, 1'b0, 1'b0);

    finishRun();
  end

endmodule